// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This block stamps the edges of one digital input with the value of a free-running counter. The input goes through a synchronizer and then an edge detector. A small sequencer steps through up to four event slots. Each slot picks its own edge direction and decides whether the counter is cleared once the slot has taken its value. This lets software measure absolute edge times, pulse widths, periods or duty cycles without help from a processor.

The sequencer has two modes. In continuous mode it wraps back to slot 0 after the last slot in use. In one-shot mode it freezes after that slot until a rearm pulse arrives. Every capture sets a sticky event flag. Slots that are enabled in a mask also raise a sticky interrupt line. All flags clear through a write-one-to-clear strobe. A sync input, or a sync pulse from software, preloads the counter from a phase value. Captured values come out on one flat parallel bus.

Top module: `edge_stamp_unit`

## Requirements
- R1: After reset, tsCount, every capture value, evtFlags, irq, slotPtr and frozen are all zero.
- R2: A change on sigIn is captured at the third rising clock edge after the change. The value stored is the counter value in the cycle before that edge, and one input transition gives exactly one capture.
- R3: slotPol bit i selects the edge for slot i: 0 means a rising edge, 1 means a falling edge. An edge of the other kind does not advance the sequencer.
- R4: When slotRst bit i is 1, the counter goes to zero on the same edge that stores its pre-clear value into slot i. A capture that lands N clocks after such a clearing capture therefore holds N-1. When the bit is 0, the counter keeps running.
- R5: In one-shot mode (oneShot=1), the sequencer freezes (frozen=1) after it captures into slot stopCount. Edges that arrive while it is frozen change no capture value, flag or pointer.
- R6: A rearm pulse sets slotPtr to 0 and frozen to 0 on the next edge.
- R7: In continuous mode (oneShot=0), slotPtr wraps to 0 after slot stopCount, frozen stays 0, and later edges overwrite the slots starting again from slot 0.
- R8: A capture into slot i sets irq only when intMask bit i is 1.
- R9: evtFlags bit i (slot i) and irq stay set until a flagClr pulse with bit i set, or with bit 4 set for irq, clears them.
- R10: While loadEn is 0, edges cause no capture, no flag and no pointer step.
- R11: The counter rises by one each clock only while runEn is 1. When runEn is 0 it holds its value.
- R12: swSync always loads phaseVal into the counter on the next edge. syncIn does the same only while syncInEn is 1. A sync load takes priority over the clear that a capture would cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sigIn | input | 1 | Input signal to timestamp (asynchronous) |
| runEn | input | 1 | Counter run control |
| loadEn | input | 1 | Capture load enable |
| oneShot | input | 1 | 1 = one-shot, 0 = continuous |
| stopCount | input | 2 | Index of the last slot used |
| slotPol | input | 4 | Edge direction for each slot (1 = falling) |
| slotRst | input | 4 | Clear the counter after capture, per slot |
| rearm | input | 1 | Rearm pulse |
| intMask | input | 4 | Interrupt enable for each slot |
| flagClr | input | 5 | Write-one-to-clear pulse: bits 3:0 clear the event flags, bit 4 clears irq |
| syncInEn | input | 1 | Enable for the external sync |
| syncIn | input | 1 | External sync pulse |
| swSync | input | 1 | Software sync pulse |
| phaseVal | input | 32 | Value loaded into the counter on a sync |
| capVal | output | 128 | Capture values; slot i is at [32*i +: 32] |
| tsCount | output | 32 | Current counter value |
| evtFlags | output | 4 | Sticky event flags, one per slot |
| irq | output | 1 | Sticky interrupt |
| slotPtr | output | 2 | Slot that the next capture will use |
| frozen | output | 1 | One-shot sequence finished |

## Verification
The assertions check, on every clock, the rules that relate one cycle to the next. Captures stay unchanged while the sequencer is frozen or loads are disabled. The counter holds while nothing drives it. Flags and irq stay set until cleared. A rearm returns the pointer to slot 0, and an enabled sync loads the phase value. The bench scenarios cover what needs a whole sequence of edges. These are the edge-to-capture latency, per-slot polarity, the N-1 difference after a clearing capture, the freeze point in one-shot mode, wrap-around and overwrite in continuous mode, and the interrupt mask.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;
  localparam int NUM_SLOTS = 4;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic              capture;   // store counter into slot
    logic [SLOT_W-1:0] slot;      // target slot
    logic              ctrClear;  // clear counter after capture
    logic              syncLoad;  // preload counter from phase value
  } dpStrobe_t;
endpackage

// File: rtl/edge_stamp_ctrl.sv
module edge_stamp_ctrl
  import edge_stamp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sigIn,
  input  logic                 loadEn,
  input  logic                 oneShot,
  input  logic [SLOT_W-1:0]    stopCount,
  input  logic [NUM_SLOTS-1:0] slotPol,
  input  logic [NUM_SLOTS-1:0] slotRst,
  input  logic                 rearm,
  input  logic [NUM_SLOTS-1:0] intMask,
  input  logic [NUM_SLOTS:0]   flagClr,
  input  logic                 syncInEn,
  input  logic                 syncIn,
  input  logic                 swSync,
  output dpStrobe_t            strobe,
  output logic [NUM_SLOTS-1:0] evtFlags,
  output logic                 irq,
  output logic [SLOT_W-1:0]    slotPtr,
  output logic                 frozen
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic sigSync, sigDly;
  logic riseHit, fallHit, edgeHit, evtFire, lastSlot;

  // input synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], sigIn};
  end
  assign sigSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sigDly <= 1'b0;
    else       sigDly <= sigSync;
  end

  assign riseHit  = sigSync & ~sigDly;
  assign fallHit  = ~sigSync & sigDly;
  assign edgeHit  = slotPol[slotPtr] ? fallHit : riseHit;
  assign evtFire  = edgeHit & loadEn & ~frozen;
  assign lastSlot = (slotPtr >= stopCount);

  always_comb begin
    strobe.capture  = evtFire;
    strobe.slot     = slotPtr;
    strobe.ctrClear = evtFire & slotRst[slotPtr];
    strobe.syncLoad = swSync | (syncInEn & syncIn);
  end

  // sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotPtr <= '0;
      frozen  <= 1'b0;
    end else if (rearm) begin
      slotPtr <= '0;
      frozen  <= 1'b0;
    end else if (evtFire) begin
      if (lastSlot) begin
        if (oneShot) frozen  <= 1'b1;
        else         slotPtr <= '0;
      end else begin
        slotPtr <= slotPtr + 1'b1;
      end
    end
  end

  // sticky flags, write-one-to-clear
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) evtFlags[i] <= 1'b0;
      else evtFlags[i] <= (evtFire && (slotPtr == SLOT_W'(i))) |
                          (evtFlags[i] & ~flagClr[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= (evtFire & intMask[slotPtr]) | (irq & ~flagClr[NUM_SLOTS]);
  end
endmodule

// File: rtl/edge_stamp_dp.sv
module edge_stamp_dp
  import edge_stamp_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       runEn,
  input  logic [CNT_W-1:0]           phaseVal,
  input  dpStrobe_t                  strobe,
  output logic [NUM_SLOTS*CNT_W-1:0] capVal,
  output logic [CNT_W-1:0]           tsCount
);
  // counter: sync load beats capture clear beats run
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                tsCount <= '0;
    else if (strobe.syncLoad) tsCount <= phaseVal;
    else if (strobe.ctrClear) tsCount <= '0;
    else if (runEn)           tsCount <= tsCount + 1'b1;
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        capVal[i*CNT_W +: CNT_W] <= '0;
      else if (strobe.capture && (strobe.slot == SLOT_W'(i)))
        capVal[i*CNT_W +: CNT_W] <= tsCount;
    end
  end
endmodule

// File: rtl/edge_stamp_unit.sv
module edge_stamp_unit
  import edge_stamp_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sigIn,
  input  logic                       runEn,
  input  logic                       loadEn,
  input  logic                       oneShot,
  input  logic [SLOT_W-1:0]          stopCount,
  input  logic [NUM_SLOTS-1:0]       slotPol,
  input  logic [NUM_SLOTS-1:0]       slotRst,
  input  logic                       rearm,
  input  logic [NUM_SLOTS-1:0]       intMask,
  input  logic [NUM_SLOTS:0]         flagClr,
  input  logic                       syncInEn,
  input  logic                       syncIn,
  input  logic                       swSync,
  input  logic [CNT_W-1:0]           phaseVal,
  output logic [NUM_SLOTS*CNT_W-1:0] capVal,
  output logic [CNT_W-1:0]           tsCount,
  output logic [NUM_SLOTS-1:0]       evtFlags,
  output logic                       irq,
  output logic [SLOT_W-1:0]          slotPtr,
  output logic                       frozen
);
  dpStrobe_t strobe;

  edge_stamp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .loadEn(loadEn), .oneShot(oneShot),
    .stopCount(stopCount), .slotPol(slotPol), .slotRst(slotRst), .rearm(rearm),
    .intMask(intMask), .flagClr(flagClr), .syncInEn(syncInEn), .syncIn(syncIn),
    .swSync(swSync), .strobe(strobe), .evtFlags(evtFlags), .irq(irq),
    .slotPtr(slotPtr), .frozen(frozen)
  );

  edge_stamp_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .runEn(runEn), .phaseVal(phaseVal),
    .strobe(strobe), .capVal(capVal), .tsCount(tsCount)
  );
endmodule

// File: rtl/edge_stamp_chk.sv
module edge_stamp_chk
  import edge_stamp_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       runEn,
  input logic                       loadEn,
  input logic                       rearm,
  input logic [NUM_SLOTS:0]         flagClr,
  input logic                       syncInEn,
  input logic                       syncIn,
  input logic                       swSync,
  input logic [CNT_W-1:0]           phaseVal,
  input logic [NUM_SLOTS*CNT_W-1:0] capVal,
  input logic [CNT_W-1:0]           tsCount,
  input logic [NUM_SLOTS-1:0]       evtFlags,
  input logic                       irq,
  input logic [SLOT_W-1:0]          slotPtr,
  input logic                       frozen
);
  p_frozen_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    frozen |=> $stable(capVal));

  p_load_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> ($stable(capVal) && $stable(slotPtr)));

  p_rearm_r6: assert property (@(posedge clk) disable iff (!rstN)
    rearm |=> (slotPtr == '0 && !frozen));

  p_run_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !loadEn && !swSync && !(syncInEn && syncIn)) |=> $stable(tsCount));

  p_sync_load_r12: assert property (@(posedge clk) disable iff (!rstN)
    (swSync || (syncInEn && syncIn)) |=> (tsCount == $past(phaseVal)));

  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !flagClr[NUM_SLOTS]) |=> irq);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(evtFlags) & ~$past(flagClr[NUM_SLOTS-1:0])) & ~evtFlags) == '0));
endmodule

bind edge_stamp_unit edge_stamp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .loadEn(loadEn), .rearm(rearm),
  .flagClr(flagClr), .syncInEn(syncInEn), .syncIn(syncIn), .swSync(swSync),
  .phaseVal(phaseVal), .capVal(capVal), .tsCount(tsCount), .evtFlags(evtFlags),
  .irq(irq), .slotPtr(slotPtr), .frozen(frozen)
);

// File: tb/edge_stamp_unit_bench.sv
module edge_stamp_unit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sigIn = 0, runEn = 0, loadEn = 0, oneShot = 0, rearm = 0;
  logic [1:0] stopCount = 0;
  logic [3:0] slotPol = 0, slotRst = 0, intMask = 0;
  logic [4:0] flagClr = 0;
  logic syncInEn = 0, syncIn = 0, swSync = 0;
  logic [31:0] phaseVal = 0;
  logic [127:0] capVal;
  logic [31:0] tsCount;
  logic [3:0] evtFlags;
  logic irq;
  logic [1:0] slotPtr;
  logic frozen;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  edge_stamp_unit u_edge_stamp_unit (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .runEn(runEn), .loadEn(loadEn),
    .oneShot(oneShot), .stopCount(stopCount), .slotPol(slotPol), .slotRst(slotRst),
    .rearm(rearm), .intMask(intMask), .flagClr(flagClr), .syncInEn(syncInEn),
    .syncIn(syncIn), .swSync(swSync), .phaseVal(phaseVal), .capVal(capVal),
    .tsCount(tsCount), .evtFlags(evtFlags), .irq(irq), .slotPtr(slotPtr),
    .frozen(frozen)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] slotVal(input int i);
    return capVal[i*32 +: 32];
  endfunction

  // drive one input transition; return counter value just before the capture edge
  task automatic edgeTo(input logic val, output logic [31:0] preCnt);
    @(negedge clk) sigIn = val;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk) preCnt = tsCount;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulseRearm();
    @(negedge clk) rearm = 1;
    @(negedge clk) rearm = 0;
  endtask

  task automatic clearAll();
    @(negedge clk) flagClr = 5'b11111;
    @(negedge clk) flagClr = 0;
  endtask

  task automatic testReset();
    chk("R1 tsCount", tsCount, 0);
    chk("R1 capVal", 32'(|capVal), 0);
    chk("R1 flags", 32'(evtFlags), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 ptr", 32'(slotPtr), 0);
    chk("R1 frozen", 32'(frozen), 0);
  endtask

  task automatic testRun();
    logic [31:0] base;
    repeat (4) @(negedge clk);
    chk("R11 idle hold", tsCount, 0);
    runEn = 1;
    base = tsCount;
    repeat (10) @(negedge clk);
    chk("R11 count", tsCount, base + 10);
  endtask

  task automatic testOneShot();
    logic [31:0] t0, t1, tx;
    oneShot = 1; stopCount = 1; slotPol = 4'b0010; slotRst = 4'b0010;
    intMask = 4'b0010; loadEn = 1;
    edgeTo(1, t0);
    chk("R2 slot0 abs", slotVal(0), t0);
    chk("R3 ptr after rise", 32'(slotPtr), 1);
    chk("R9 flag0", 32'(evtFlags), 4'b0001);
    chk("R8 masked slot0", 32'(irq), 0);
    chk("R4 no clear slot0", 32'(tsCount > t0), 1);
    repeat (10) @(negedge clk);
    edgeTo(0, t1);
    chk("R3 slot1 falling", slotVal(1), t1);
    chk("R4 clear after slot1", tsCount, 0);
    chk("R5 frozen", 32'(frozen), 1);
    chk("R9 flags", 32'(evtFlags), 4'b0011);
    chk("R8 irq slot1", 32'(irq), 1);
    // frozen: edges ignored
    edgeTo(1, tx);
    edgeTo(0, tx);
    chk("R5 slot0 kept", slotVal(0), t0);
    chk("R5 slot1 kept", slotVal(1), t1);
    chk("R5 ptr kept", 32'(slotPtr), 1);
    repeat (5) @(negedge clk);
    chk("R9 flags sticky", 32'(evtFlags), 4'b0011);
    chk("R9 irq sticky", 32'(irq), 1);
    clearAll();
    chk("R9 flags cleared", 32'(evtFlags), 0);
    chk("R9 irq cleared", 32'(irq), 0);
  endtask

  task automatic testRearm();
    logic [31:0] t0;
    pulseRearm();
    chk("R6 ptr", 32'(slotPtr), 0);
    chk("R6 frozen", 32'(frozen), 0);
    edgeTo(1, t0);
    chk("R6 recapture", slotVal(0), t0);
    chk("R8 no irq slot0", 32'(irq), 0);
    edgeTo(0, t0);
    chk("R5 refreeze", 32'(frozen), 1);
    clearAll();
  endtask

  task automatic testLoadGate();
    logic [31:0] keep, tx;
    pulseRearm();
    keep = slotVal(0);
    loadEn = 0;
    edgeTo(1, tx);
    chk("R10 no capture", slotVal(0), keep);
    chk("R10 ptr", 32'(slotPtr), 0);
    chk("R10 flags", 32'(evtFlags), 0);
    edgeTo(0, tx);
    loadEn = 1;
  endtask

  task automatic testContinuous();
    logic [31:0] a, b, c, d, e;
    oneShot = 0; stopCount = 3; slotPol = 4'b1010; slotRst = 4'b1111;
    intMask = 4'b1000;
    pulseRearm();
    edgeTo(1, a);
    chk("R8 no irq slot0", 32'(irq), 0);
    edgeTo(0, b);
    edgeTo(1, c);
    edgeTo(0, d);
    chk("R4 diff slot1", slotVal(1), 3);
    chk("R4 diff slot2", slotVal(2), 3);
    chk("R4 diff slot3", slotVal(3), 3);
    chk("R7 wrap ptr", 32'(slotPtr), 0);
    chk("R7 not frozen", 32'(frozen), 0);
    chk("R8 irq slot3", 32'(irq), 1);
    edgeTo(1, e);
    chk("R7 overwrite slot0", slotVal(0), 3);
    chk("R7 ptr step", 32'(slotPtr), 1);
    edgeTo(0, e);
    clearAll();
  endtask

  task automatic testSync();
    logic [31:0] pre;
    loadEn = 0;
    @(negedge clk) phaseVal = 32'h1000; syncInEn = 0; syncIn = 1;
    pre = tsCount;
    @(negedge clk) syncIn = 0;
    chk("R12 sync ignored", tsCount, pre + 1);
    syncInEn = 1; syncIn = 1;
    @(negedge clk) syncIn = 0;
    chk("R12 sync load", tsCount, 32'h1000);
    syncInEn = 0; phaseVal = 32'h2000; swSync = 1;
    @(negedge clk) swSync = 0;
    chk("R12 sw sync", tsCount, 32'h2000);
    runEn = 0;
    pre = tsCount;
    repeat (5) @(negedge clk);
    chk("R11 stopped", tsCount, pre);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testRun();
    testOneShot();
    testRearm();
    testLoadGate();
    testContinuous();
    testSync();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule